// File: doc/BRIEF.md
# Cell Protection Fault Qualifier

This block sits between a bank of analog cell comparators and the host of a battery-monitor chip. It takes raw per-cell overvoltage and undervoltage indications and two overtemperature indications. It qualifies each of the three fault sources with its own programmable persistence timer. It latches the qualified flags into a fault status word and an alert status word, and drives a fault pin and an alert pin from the OR of those words. The host clears flags by writing ones through a parallel write port. Each clear restarts the persistence timer of that source, so a condition that never goes away is reported again every time its timer runs out.

Two further functions shape what the timers see. A wake blanker ignores every comparator while the chip is asleep and for a programmed number of ticks after it wakes. A configured cell count removes the cells above that count from overvoltage and undervoltage detection. All timing is counted in ticks of a divider that runs from the system clock.

Each source timer is a three-state machine. IDLE moves to COUNT when the masked condition is present. COUNT moves back to IDLE when the condition drops, and moves to HOLD on expiry, which is also when the flags latch. HOLD moves to IDLE when the condition drops. A clear, or a hold time of zero, forces the machine to IDLE. The wake blanker has three states. AWAKE moves to ASLEEP on a sleep request. ASLEEP moves to BLANK when the request drops. BLANK moves to AWAKE after BLANK_TICKS ticks, or back to ASLEEP if the request returns.

Top module: `cell_guard_ctrl`

## Requirements
- R1: After reset both status words are zero and both pins are low.
- R2: With a non-zero hold time H, a source's flags latch once its masked condition has been present without a break for H ticks. They latch on the clock edge at which the H-th tick ends, counted from the first cycle after the state machine enters COUNT. Only the cells active at that edge are latched. If the condition drops while counting, the count returns to zero.
- R3: With a hold time of zero, the flags of that source copy the masked condition one cycle later and are not latched. A write-one clear to that source has no effect.
- R4: fault_pin is the OR of fault_word and alert_pin is the OR of alert_word. With non-zero hold times, latched flags and pins stay set until the host clears them.
- R5: A write with wr_en high clears every flag written as 1 in the selected word and restarts that source's timer. If the condition persists, the flag sets again after another full hold time, and this repeats.
- R6: When a clear and a timer expiry for the same source fall in the same cycle, the clear wins. No flag of that source sets in that cycle and its count restarts from zero.
- R7: While sleep_req is high, and for BLANK_TICKS ticks after it falls, every raw input reads as inactive. Flags already latched are kept. A rising sleep_req during blanking returns to the asleep state.
- R8: Cell i (counted from 0) takes part in overvoltage and undervoltage detection only when cell_cfg is greater than i. For example, cell_cfg = 4 ignores cells 4 and 5.
- R9: A cell_cfg value above NUM_CELLS acts as NUM_CELLS.
- R10: fault_word bit i is the overvoltage flag of cell i and bit NUM_CELLS+i is its undervoltage flag. alert_word bit j is overtemperature input j. A write with wr_sel = 0 clears fault_word bits from wr_data. A write with wr_sel = 1 clears alert_word bits from wr_data[NUM_OT-1:0].
- R11: One tick occurs every TICK_DIV clock cycles. The first tick is in the TICK_DIV-th cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | High while the chip is asleep |
| cell_cfg | input | CW | Number of connected cells |
| ov_raw | input | NUM_CELLS | Raw overvoltage comparator outputs |
| uv_raw | input | NUM_CELLS | Raw undervoltage comparator outputs |
| ot_raw | input | NUM_OT | Raw overtemperature comparator outputs |
| ov_hold | input | TW | Overvoltage hold time in ticks, 0 = transparent |
| uv_hold | input | TW | Undervoltage hold time in ticks, 0 = transparent |
| ot_hold | input | TW | Overtemperature hold time in ticks, 0 = transparent |
| wr_en | input | 1 | Write-one-to-clear strobe |
| wr_sel | input | 1 | 0 selects the fault word, 1 selects the alert word |
| wr_data | input | 2*NUM_CELLS | Bits to clear |
| fault_word | output | 2*NUM_CELLS | Latched overvoltage and undervoltage flags |
| alert_word | output | NUM_OT | Latched overtemperature flags |
| fault_pin | output | 1 | OR of fault_word |
| alert_pin | output | 1 | OR of alert_word |

## Verification
A host clear and a timer expiry for the same source can land on the same edge, and the clear must win. The bench provokes this by starting a persistent condition and then sweeping the clear across every cycle offset around the expected expiry. Random clears during random persistent conditions add more collisions. A cycle-accurate reference model in the bench, written from R2, R5 and R6, gives the expected words on every cycle. A wrong priority shows up either as a flag that survives its own clear or as a re-assertion one hold time too early.

// File: rtl/cgc_pkg.sv
package cgc_pkg;

    typedef enum logic [1:0] {
        Q_IDLE  = 2'd0,
        Q_COUNT = 2'd1,
        Q_HOLD  = 2'd2
    } qual_state_e;

    typedef enum logic [1:0] {
        W_AWAKE  = 2'd0,
        W_ASLEEP = 2'd1,
        W_BLANK  = 2'd2
    } wake_state_e;

endpackage

// File: rtl/cgc_tick_gen.sv
module cgc_tick_gen #(
    parameter int TICK_DIV = 5000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV > 1) begin : g_div
            logic [DW-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                         div_q <= '0;
                else if (div_q == DW'(TICK_DIV-1))  div_q <= '0;
                else                                div_q <= div_q + 1'b1;
            end

            assign tick = (div_q == DW'(TICK_DIV-1));

            // R11: a tick never lasts two cycles
            p_tick_isolated_r11: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_every
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/cgc_wake_blank.sv
module cgc_wake_blank
    import cgc_pkg::*;
#(
    parameter int BLANK_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sleep_req,
    output logic blank
);
    localparam int BW = (BLANK_TICKS > 1) ? $clog2(BLANK_TICKS) : 1;

    wake_state_e   st_q, st_d;
    logic [BW-1:0] bcnt_q, bcnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= W_AWAKE;
            bcnt_q <= '0;
        end else begin
            st_q   <= st_d;
            bcnt_q <= bcnt_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        bcnt_d = bcnt_q;
        unique case (st_q)
            W_AWAKE: begin
                if (sleep_req) st_d = W_ASLEEP;
            end
            W_ASLEEP: begin
                if (!sleep_req) begin
                    st_d   = W_BLANK;
                    bcnt_d = '0;
                end
            end
            W_BLANK: begin
                if (sleep_req) begin
                    st_d = W_ASLEEP;
                end else if (tick) begin
                    if (bcnt_q == BW'(BLANK_TICKS-1)) st_d = W_AWAKE;
                    else                              bcnt_d = bcnt_q + 1'b1;
                end
            end
            default: st_d = W_AWAKE;
        endcase
    end

    assign blank = (st_q != W_AWAKE);

    // R7: leaving sleep always passes through blanking
    p_wake_enters_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == W_ASLEEP && !sleep_req) |=> (st_q == W_BLANK));

    // R7: a sleep request blanks the inputs from the next cycle
    p_sleep_blanks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> blank);
endmodule

// File: rtl/cgc_fault_qual.sv
module cgc_fault_qual
    import cgc_pkg::*;
#(
    parameter int W  = 6,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [W-1:0]  cond,
    input  logic [TW-1:0] limit,
    input  logic [W-1:0]  clr_bits,
    output logic [W-1:0]  flags
);
    qual_state_e   st_q, st_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic [W-1:0]  flags_d;
    logic          lim_off, active, clr_any, at_end;

    assign lim_off = (limit == '0);
    assign active  = |cond;
    assign clr_any = |clr_bits;
    assign at_end  = (cnt_q >= limit - TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= Q_IDLE;
            cnt_q <= '0;
            flags <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            flags <= flags_d;
        end
    end

    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        flags_d = flags;
        if (lim_off) begin
            st_d    = Q_IDLE;
            cnt_d   = '0;
            flags_d = cond;
        end else if (clr_any) begin
            st_d    = Q_IDLE;
            cnt_d   = '0;
            flags_d = flags & ~clr_bits;
        end else begin
            unique case (st_q)
                Q_IDLE: begin
                    if (active) begin
                        st_d  = Q_COUNT;
                        cnt_d = '0;
                    end
                end
                Q_COUNT: begin
                    if (!active) begin
                        st_d  = Q_IDLE;
                        cnt_d = '0;
                    end else if (tick) begin
                        if (at_end) begin
                            st_d    = Q_HOLD;
                            cnt_d   = '0;
                            flags_d = flags | cond;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                Q_HOLD: begin
                    if (!active) st_d = Q_IDLE;
                end
                default: st_d = Q_IDLE;
            endcase
        end
    end

    // R3: a zero hold time makes the flags a one-cycle copy of the condition
    p_transparent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lim_off |=> (flags == $past(cond)));

    // R6: bits written as one are clear on the next cycle, even on expiry
    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lim_off && clr_any) |=> ((flags & $past(clr_bits)) == '0));

    // R2: the hold state is reached only from counting, on a tick
    p_hold_after_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == Q_HOLD && $past(st_q) != Q_HOLD) |-> ($past(st_q) == Q_COUNT && $past(tick)));
endmodule

// File: rtl/cell_guard_ctrl.sv
module cell_guard_ctrl #(
    parameter int NUM_CELLS   = 6,
    parameter int NUM_OT      = 2,
    parameter int TW          = 16,
    parameter int TICK_DIV    = 5000,
    parameter int BLANK_TICKS = 2,
    localparam int CW         = $clog2(NUM_CELLS + 1),
    localparam int FW         = 2 * NUM_CELLS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_req,
    input  logic [CW-1:0] cell_cfg,
    input  logic [NUM_CELLS-1:0] ov_raw,
    input  logic [NUM_CELLS-1:0] uv_raw,
    input  logic [NUM_OT-1:0]    ot_raw,
    input  logic [TW-1:0] ov_hold,
    input  logic [TW-1:0] uv_hold,
    input  logic [TW-1:0] ot_hold,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [FW-1:0] wr_data,
    output logic [FW-1:0] fault_word,
    output logic [NUM_OT-1:0] alert_word,
    output logic          fault_pin,
    output logic          alert_pin
);
    logic                 tick, blank;
    logic [NUM_CELLS-1:0] cell_en;
    logic [NUM_CELLS-1:0] cell_raw   [2];
    logic [TW-1:0]        cell_hold  [2];
    logic [NUM_CELLS-1:0] cell_flags [2];
    logic [NUM_CELLS-1:0] cell_clr   [2];
    logic [NUM_OT-1:0]    ot_cond, ot_clr;

    cgc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    cgc_wake_blank #(.BLANK_TICKS(BLANK_TICKS)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sleep_req (sleep_req),
        .blank     (blank)
    );

    always_comb begin
        for (int i = 0; i < NUM_CELLS; i++) begin
            cell_en[i] = (int'(cell_cfg) > i);
        end
    end

    assign cell_raw[0]  = ov_raw;
    assign cell_raw[1]  = uv_raw;
    assign cell_hold[0] = ov_hold;
    assign cell_hold[1] = uv_hold;

    generate
        for (genvar s = 0; s < 2; s++) begin : g_cell_src
            logic [NUM_CELLS-1:0] cond;
            assign cond        = cell_raw[s] & cell_en & {NUM_CELLS{~blank}};
            assign cell_clr[s] = (wr_en && !wr_sel) ?
                                 wr_data[s*NUM_CELLS +: NUM_CELLS] : '0;

            cgc_fault_qual #(.W(NUM_CELLS), .TW(TW)) u_qual (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (tick),
                .cond     (cond),
                .limit    (cell_hold[s]),
                .clr_bits (cell_clr[s]),
                .flags    (cell_flags[s])
            );
        end
    endgenerate

    assign ot_cond = ot_raw & {NUM_OT{~blank}};
    assign ot_clr  = (wr_en && wr_sel) ? wr_data[NUM_OT-1:0] : '0;

    cgc_fault_qual #(.W(NUM_OT), .TW(TW)) u_ot_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cond     (ot_cond),
        .limit    (ot_hold),
        .clr_bits (ot_clr),
        .flags    (alert_word)
    );

    assign fault_word = {cell_flags[1], cell_flags[0]};
    assign fault_pin  = |fault_word;
    assign alert_pin  = |alert_word;

    // R4: with both cell hold times set, the fault pin drops only on a clear
    p_pin_latched_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_pin && !(wr_en && !wr_sel) && ov_hold != '0 && uv_hold != '0) |=> fault_pin);

    // R8: a masked cell never gains an overvoltage or undervoltage flag
    p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((cell_flags[0] & ~$past(cell_flags[0])) & ~$past(cell_en)) == '0 &&
                  ((cell_flags[1] & ~$past(cell_flags[1])) & ~$past(cell_en)) == '0));
endmodule

// File: tb/cell_guard_ctrl_tb_top.sv
module cell_guard_ctrl_tb_top;
    localparam int NC = 6;
    localparam int NT = 2;
    localparam int TW = 8;
    localparam int TD = 4;
    localparam int BT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_req = 1'b0;
    logic [2:0]    cell_cfg = 3'd6;
    logic [NC-1:0] ov_raw = '0, uv_raw = '0;
    logic [NT-1:0] ot_raw = '0;
    logic [TW-1:0] ov_hold = 8'd3, uv_hold = 8'd3, ot_hold = 8'd3;
    logic          wr_en = 1'b0, wr_sel = 1'b0;
    logic [2*NC-1:0] wr_data = '0;
    logic [2*NC-1:0] fault_word;
    logic [NT-1:0] alert_word;
    logic          fault_pin, alert_pin;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    cell_guard_ctrl #(.NUM_CELLS(NC), .NUM_OT(NT), .TW(TW), .TICK_DIV(TD), .BLANK_TICKS(BT)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cell_cfg(cell_cfg),
        .ov_raw(ov_raw), .uv_raw(uv_raw), .ot_raw(ot_raw),
        .ov_hold(ov_hold), .uv_hold(uv_hold), .ot_hold(ot_hold),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .fault_word(fault_word), .alert_word(alert_word),
        .fault_pin(fault_pin), .alert_pin(alert_pin)
    );

    // reference model, written from the requirements
    int       m_div, m_wst, m_bcnt;
    int       m_st  [3];
    int       m_cnt [3];
    logic [5:0] m_fl [3];

    function automatic logic [5:0] cell_mask(input logic [2:0] c);
        if (c >= 3'd6) return 6'h3f;
        return 6'((7'd1 << c) - 7'd1);
    endfunction

    task automatic src_step(input int s, input logic [5:0] c, input logic [7:0] lim,
                            input logic [5:0] cb, input logic tk);
        if (lim == 0) begin
            m_st[s] = 0; m_cnt[s] = 0; m_fl[s] = c;
        end else if (cb != 0) begin
            m_st[s] = 0; m_cnt[s] = 0; m_fl[s] = m_fl[s] & ~cb;
        end else if (m_st[s] == 0) begin
            if (c != 0) begin m_st[s] = 1; m_cnt[s] = 0; end
        end else if (m_st[s] == 1) begin
            if (c == 0) begin
                m_st[s] = 0; m_cnt[s] = 0;
            end else if (tk) begin
                if (m_cnt[s] >= int'(lim) - 1) begin
                    m_st[s] = 2; m_cnt[s] = 0; m_fl[s] = m_fl[s] | c;
                end else m_cnt[s] = m_cnt[s] + 1;
            end
        end else begin
            if (c == 0) m_st[s] = 0;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_div = 0; m_wst = 0; m_bcnt = 0;
            for (int s = 0; s < 3; s++) begin m_st[s] = 0; m_cnt[s] = 0; m_fl[s] = '0; end
        end else begin
            logic tk, bl;
            logic [5:0] en, cov, cuv, cot, cb_ov, cb_uv, cb_ot;
            tk  = (m_div == TD - 1);
            bl  = (m_wst != 0);
            en  = cell_mask(cell_cfg);
            cov = bl ? 6'd0 : (ov_raw & en);
            cuv = bl ? 6'd0 : (uv_raw & en);
            cot = bl ? 6'd0 : {4'd0, ot_raw};
            cb_ov = (wr_en && !wr_sel) ? wr_data[5:0]  : 6'd0;
            cb_uv = (wr_en && !wr_sel) ? wr_data[11:6] : 6'd0;
            cb_ot = (wr_en &&  wr_sel) ? {4'd0, wr_data[1:0]} : 6'd0;
            src_step(0, cov, ov_hold, cb_ov, tk);
            src_step(1, cuv, uv_hold, cb_uv, tk);
            src_step(2, cot, ot_hold, cb_ot, tk);
            m_div = tk ? 0 : m_div + 1;
            if (m_wst == 0) begin
                if (sleep_req) m_wst = 1;
            end else if (m_wst == 1) begin
                if (!sleep_req) begin m_wst = 2; m_bcnt = 0; end
            end else begin
                if (sleep_req) m_wst = 1;
                else if (tk) begin
                    if (m_bcnt == BT - 1) m_wst = 0;
                    else m_bcnt = m_bcnt + 1;
                end
            end
        end
    end

    task automatic step(input string tag);
        logic [11:0] ef;
        logic [1:0]  ea;
        @(negedge clk);
        ef = {m_fl[1], m_fl[0]};
        ea = m_fl[2][1:0];
        vectors++;
        if (fault_word !== ef || alert_word !== ea ||
            fault_pin !== (|ef) || alert_pin !== (|ea)) begin
            misses++;
            $display("FAIL %s: fault_word=%h alert_word=%b pins=%b%b expected %h %b %b%b",
                     tag, fault_word, alert_word, fault_pin, alert_pin,
                     ef, ea, |ef, |ea);
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    task automatic clear(input logic sel, input logic [11:0] d, input string tag);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step(tag);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: run still busy, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        run(2, "R1");
        rst_n = 1'b1;
        run(2, "R1");

        // R2/R11: persistence on one cell, then a glitch that resets the count
        ov_raw = 6'b000001;
        run(20, "R2");
        ov_raw = 6'b000011;
        run(6, "R11");
        ov_raw = '0;
        run(6, "R4");
        uv_raw = 6'b000100;
        run(5, "R2");
        uv_raw = '0;
        run(2, "R2");
        uv_raw = 6'b000100;
        run(20, "R2");

        // R5/R10: clear restarts the timer, persisting fault re-asserts
        clear(1'b0, 12'hfff, "R10");
        run(20, "R5");
        clear(1'b0, 12'h100, "R5");
        run(20, "R5");
        uv_raw = '0;
        clear(1'b0, 12'hfff, "R5");
        run(4, "R4");

        // R3: zero hold is transparent and unlatched, clear ignored
        ot_hold = 8'd0;
        ot_raw = 2'b10;
        run(3, "R3");
        clear(1'b1, 12'h003, "R3");
        run(2, "R3");
        ot_raw = 2'b01;
        run(2, "R3");
        ot_raw = '0;
        run(2, "R3");
        ot_hold = 8'd2;

        // R6: sweep a clear across every offset around expiry
        for (int off = 0; off < 18; off++) begin
            ot_raw = 2'b11;
            run(off, "R6");
            clear(1'b1, 12'h001, "R6");
            run(3, "R6");
            ot_raw = '0;
            clear(1'b1, 12'h003, "R6");
            run(2, "R6");
        end

        // R7: sleep and post-wake blanking
        ov_raw = 6'b001000;
        sleep_req = 1'b1;
        run(10, "R7");
        sleep_req = 1'b0;
        run(5, "R7");
        sleep_req = 1'b1;
        run(3, "R7");
        sleep_req = 1'b0;
        run(30, "R7");
        ov_raw = '0;
        clear(1'b0, 12'hfff, "R7");

        // R8: four cells configured, upper cells ignored
        cell_cfg = 3'd4;
        ov_raw = 6'b110000;
        uv_raw = 6'b100000;
        run(25, "R8");
        ov_raw = 6'b111000;
        run(25, "R8");
        clear(1'b0, 12'hfff, "R8");
        ov_raw = '0; uv_raw = '0;
        // R9: count above six acts as six
        cell_cfg = 3'd7;
        uv_raw = 6'b100000;
        run(25, "R9");
        uv_raw = '0;
        clear(1'b0, 12'hfff, "R9");
        cell_cfg = 3'd6;

        // R4: constrained random mix
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(15) == 0) ov_raw[$urandom_range(NC-1)] ^= 1'b1;
            if ($urandom_range(15) == 0) uv_raw[$urandom_range(NC-1)] ^= 1'b1;
            if ($urandom_range(31) == 0) ot_raw[$urandom_range(NT-1)] ^= 1'b1;
            if ($urandom_range(299) == 0) sleep_req = ~sleep_req;
            if ($urandom_range(499) == 0) cell_cfg = 3'($urandom_range(7));
            if ($urandom_range(399) == 0) ov_hold = ($urandom_range(4) == 0) ? 8'd0 : 8'($urandom_range(1, 4));
            if ($urandom_range(399) == 0) uv_hold = ($urandom_range(4) == 0) ? 8'd0 : 8'($urandom_range(1, 4));
            if ($urandom_range(399) == 0) ot_hold = ($urandom_range(4) == 0) ? 8'd0 : 8'($urandom_range(1, 4));
            if ($urandom_range(39) == 0) begin
                wr_en = 1'b1;
                wr_sel = 1'($urandom_range(1));
                wr_data = 12'($urandom);
            end else begin
                wr_en = 1'b0;
                wr_data = '0;
            end
            step("R4");
        end
        wr_en = 1'b0;
        run(2, "R4");
        finish_run();
    end
endmodule